// File: doc/BRIEF.md
# Crystal Clock Loss Detector

This block watches a slow crystal clock and compares it with a free-running reference clock of about the same frequency. A counter clocked by the crystal counts through a fixed number of crystal cycles and flips an event toggle at the end of every round. The toggle crosses into the reference domain, where it becomes a one-cycle "alive" pulse. That pulse restarts a timeout counter clocked by the reference. While the crystal runs, the timeout is always restarted before it expires. If the crystal stalls, the timeout reaches its limit. The block then raises a one-cycle expiry pulse and a sticky loss flag.

Both counts are parameters. The crystal round length must be shorter than the timeout by at least the synchronizer latency margin, and a configuration that breaks this rule is rejected at elaboration. Each clock domain has its own asynchronous active-low reset, released synchronously inside the block. The `enable` input belongs to the reference domain, and a synchronized copy of it gates the crystal counter.

Top module: `xtal_fail_detect`

## Requirements
- R1: While the resets are asserted, and just after they are released, `ok_pulse`, `fail_pulse` and `fail_flag` are all low.
- R2: With `enable` high and the crystal running, `ok_pulse` is high for exactly one reference cycle, once for every XTAL_TC+1 crystal cycles. The gap between consecutive pulses, counted in reference cycles, therefore lies between floor and ceil of (XTAL_TC+1)·Tx/Tr.
- R3: While the crystal runs and that gap stays below FAIL_TC+1 reference cycles, `fail_pulse` and `fail_flag` stay low.
- R4: If no further `ok_pulse` arrives, `fail_flag` and `fail_pulse` first read high exactly FAIL_TC+1 reference cycles after the last cycle in which `ok_pulse` was high. The timeout count never exceeds FAIL_TC.
- R5: Each expiry gives exactly one `fail_pulse` cycle. While the crystal stays stopped, `fail_flag` stays high and no further pulse occurs.
- R6: In the cycle after an `ok_pulse` with `enable` high, `fail_flag` is low, so an alive event clears the sticky flag.
- R7: With `enable` low, no `ok_pulse` or `fail_pulse` is produced and the timeout does not advance. `fail_flag` keeps its value until an alive event arrives after `enable` returns high.
- R8: Once the crystal clock stops, `fail_flag` rises within FAIL_TC+5 reference cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xtal_clk | input | 1 | Monitored crystal clock |
| xtal_rst_n | input | 1 | Asynchronous active-low reset for the crystal domain |
| ref_clk | input | 1 | Independent reference clock |
| ref_rst_n | input | 1 | Asynchronous active-low reset for the reference domain |
| enable | input | 1 | Monitoring enable, synchronous to `ref_clk` |
| ok_pulse | output | 1 | One reference cycle: the crystal completed a round |
| fail_pulse | output | 1 | One reference cycle: the timeout expired |
| fail_flag | output | 1 | Sticky crystal-loss flag, cleared by the next alive event |

## Verification
The bench builds the block with XTAL_TC=7, FAIL_TC=15, SYNC_STAGES=2 and 16-bit counters. With these values a full crystal round takes 8 to 14 reference cycles, so a sweep over five crystal periods brings the healthy case close to the 16-cycle timeout. The bench stops the crystal at each of nine phases of its round. This covers the case where a toggle is still in the synchronizer when the clock stops, so the exact expiry cycle and the bound measured from the stop can be checked against hand-computed counts. Runs with `enable` low are made both with the flag set and with it clear.

// File: rtl/xfd_pkg.sv
package xfd_pkg;
  // Default counter width for both domains.
  localparam int unsigned XFD_CNT_W = 16;

  // Reference cycles lost between a crystal toggle and the timer restart:
  // the synchronizer stages, the edge register and the timer register.
  function automatic int unsigned xfd_margin(input int unsigned stages);
    return stages + 2;
  endfunction
endpackage

// File: rtl/xfd_rst_sync.sv
module xfd_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= 2'b00;
    else         chain_q <= {chain_q[0], 1'b1};
  end

  assign rst_n = chain_q[1];
endmodule

// File: rtl/xfd_xtal_counter.sv
module xfd_xtal_counter #(
  parameter int unsigned W    = 16,
  parameter int unsigned TC   = 1000,
  parameter int unsigned SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable_in,
  output logic evt_tgl
);
  localparam logic [W-1:0] LAST = W'(TC);

  logic [SYNC-1:0] en_q;
  logic [W-1:0]    cnt_q, cnt_d;
  logic            tgl_q, tgl_d;
  logic            en_x;

  assign en_x = en_q[SYNC-1];

  // Enable is brought into the crystal domain.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= {en_q[SYNC-2:0], enable_in};
  end

  always_comb begin
    cnt_d = cnt_q;
    tgl_d = tgl_q;
    if (!en_x) begin
      cnt_d = '0;
    end else if (cnt_q == LAST) begin
      cnt_d = '0;
      tgl_d = ~tgl_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tgl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tgl_q <= tgl_d;
    end
  end

  assign evt_tgl = tgl_q;
endmodule

// File: rtl/xfd_sync_edge.sv
module xfd_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_in,
  input  logic gate,
  output logic pulse
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;
  logic              pulse_q, pulse_d;

  always_comb pulse_d = gate & (sync_q[STAGES-1] ^ last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      last_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      sync_q  <= {sync_q[STAGES-2:0], tgl_in};
      last_q  <= sync_q[STAGES-1];
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;
endmodule

// File: rtl/xfd_ref_timer.sv
module xfd_ref_timer #(
  parameter int unsigned W  = 16,
  parameter int unsigned TC = 1100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         retrig,
  output logic         expire_pulse,
  output logic         expired,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] LIMIT    = W'(TC);
  localparam logic [W-1:0] LIMIT_M1 = W'(TC - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         flag_q, flag_d;
  logic         pls_q, pls_d;

  always_comb begin
    cnt_d  = cnt_q;
    flag_d = flag_q;
    pls_d  = 1'b0;
    if (!run) begin
      cnt_d = '0;
    end else if (retrig) begin
      cnt_d  = '0;
      flag_d = 1'b0;
    end else if (cnt_q != LIMIT) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LIMIT_M1) begin
        pls_d  = 1'b1;
        flag_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
      pls_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
      pls_q  <= pls_d;
    end
  end

  assign expire_pulse = pls_q;
  assign expired      = flag_q;
  assign count        = cnt_q;
endmodule

// File: rtl/xtal_fail_detect.sv
module xtal_fail_detect #(
  parameter int unsigned CNT_W       = xfd_pkg::XFD_CNT_W,
  parameter int unsigned XTAL_TC     = 1000,
  parameter int unsigned FAIL_TC     = 1100,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic xtal_clk,
  input  logic xtal_rst_n,
  input  logic ref_clk,
  input  logic ref_rst_n,
  input  logic enable,
  output logic ok_pulse,
  output logic fail_pulse,
  output logic fail_flag
);
  localparam int unsigned MARGIN = xfd_pkg::xfd_margin(SYNC_STAGES);

  generate
    if ((XTAL_TC + MARGIN >= FAIL_TC) || ((FAIL_TC >> CNT_W) != 0) ||
        (SYNC_STAGES < 2)) begin : g_cfg_bad
      $error("xtal_fail_detect: XTAL_TC + margin must stay below FAIL_TC within CNT_W bits");
    end
  endgenerate

  logic             xrst_n, rrst_n;
  logic             evt_tgl;
  logic [CNT_W-1:0] tmr_cnt;

  xfd_rst_sync u_xrst (.clk(xtal_clk), .arst_n(xtal_rst_n), .rst_n(xrst_n));
  xfd_rst_sync u_rrst (.clk(ref_clk),  .arst_n(ref_rst_n),  .rst_n(rrst_n));

  xfd_xtal_counter #(.W(CNT_W), .TC(XTAL_TC), .SYNC(SYNC_STAGES)) u_xcnt (
    .clk(xtal_clk), .rst_n(xrst_n), .enable_in(enable), .evt_tgl(evt_tgl)
  );

  xfd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(ref_clk), .rst_n(rrst_n), .tgl_in(evt_tgl), .gate(enable), .pulse(ok_pulse)
  );

  xfd_ref_timer #(.W(CNT_W), .TC(FAIL_TC)) u_tmr (
    .clk(ref_clk), .rst_n(rrst_n), .run(enable), .retrig(ok_pulse),
    .expire_pulse(fail_pulse), .expired(fail_flag), .count(tmr_cnt)
  );
endmodule

// File: rtl/xfd_checker.sv
module xfd_checker #(
  parameter int unsigned W       = 16,
  parameter int unsigned FAIL_TC = 1100
) (
  input logic         ref_clk,
  input logic         ref_rst_n,
  input logic         enable,
  input logic         ok_pulse,
  input logic         fail_pulse,
  input logic         fail_flag,
  input logic [W-1:0] tmr_cnt
);
  assert_ok_single_R2: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    ok_pulse |=> !ok_pulse);

  assert_cnt_cap_R4: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    tmr_cnt <= W'(FAIL_TC));

  assert_cnt_hold_R4: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    (enable && !ok_pulse && tmr_cnt == W'(FAIL_TC)) |=> (tmr_cnt == W'(FAIL_TC)));

  assert_fail_single_R5: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    fail_pulse |=> !fail_pulse);

  assert_pulse_flags_R5: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    fail_pulse |-> fail_flag);

  assert_flag_sticky_R5: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    (fail_flag && !ok_pulse) |=> fail_flag);

  assert_ok_clears_R6: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    (ok_pulse && enable) |=> !fail_flag);

  assert_idle_quiet_R7: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    !enable |=> (!fail_pulse && !ok_pulse));
endmodule

bind xtal_fail_detect xfd_checker #(.W(CNT_W), .FAIL_TC(FAIL_TC)) u_chk (
  .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .enable(enable), .ok_pulse(ok_pulse),
  .fail_pulse(fail_pulse), .fail_flag(fail_flag), .tmr_cnt(tmr_cnt)
);

// File: tb/tb_xtal_fail_detect.sv
`timescale 1ns/1ps
module tb_xtal_fail_detect;
  localparam int XTC = 7;
  localparam int FTC = 15;

  logic xtal_clk = 1'b0, ref_clk = 1'b0;
  logic xtal_rst_n, ref_rst_n, enable;
  logic ok_pulse, fail_pulse, fail_flag;
  bit   xrun = 1'b1;
  real  xhalf = 2.0;
  int   checks = 0, errs = 0;

  xtal_fail_detect #(.CNT_W(16), .XTAL_TC(XTC), .FAIL_TC(FTC), .SYNC_STAGES(2)) dut (
    .xtal_clk(xtal_clk), .xtal_rst_n(xtal_rst_n), .ref_clk(ref_clk), .ref_rst_n(ref_rst_n),
    .enable(enable), .ok_pulse(ok_pulse), .fail_pulse(fail_pulse), .fail_flag(fail_flag)
  );

  always #2 ref_clk = ~ref_clk;

  // Crystal: offset by an odd number of 100 ps so its edges never meet ref edges.
  initial begin
    #0.3;
    forever begin
      #(xhalf);
      if (xrun) xtal_clk = ~xtal_clk;
    end
  end

  task automatic chk(input bit good, input string req, input int act, input int exp);
    checks++;
    if (!good) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - errs, checks);
  endtask

  initial begin
    #800000;
    errs++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  // Waits at negedges until ok_pulse is seen; n = cycles waited, -1 if none.
  int flag_hits;
  task automatic wait_ok(input int limit, output int n);
    n = 0;
    do begin
      @(negedge ref_clk);
      n++;
      if (fail_flag || fail_pulse) flag_hits++;
    end while (!ok_pulse && n < limit);
    if (!ok_pulse) n = -1;
  endtask

  task automatic run_healthy(input real hp, input int npulses);
    int n, gmin, gmax, lo, hi;
    real t;
    xhalf = hp;
    wait_ok(40, n);
    wait_ok(40, n);
    t  = 16.0 * hp / 4.0;
    lo = $rtoi(t);
    hi = ($itor(lo) == t) ? lo : lo + 1;
    gmin = 1000; gmax = 0; flag_hits = 0;
    for (int i = 0; i < npulses; i++) begin
      wait_ok(40, n);
      if (n < 0) n = 999;
      if (n < gmin) gmin = n;
      if (n > gmax) gmax = n;
    end
    chk(gmin >= lo, "R2 min gap", gmin, lo);
    chk(gmax <= hi, "R2 max gap", gmax, hi);
    @(negedge ref_clk);
    chk(ok_pulse == 1'b0, "R2 pulse width", ok_pulse, 0);
    chk(flag_hits == 0, "R3 no timeout while running", flag_hits, 0);
  endtask

  initial begin
    int n, c, last_ok, first_flag, pulses, okc, lows;
    enable = 1'b0; xtal_rst_n = 1'b0; ref_rst_n = 1'b0;
    repeat (5) @(negedge ref_clk);
    chk(!ok_pulse && !fail_pulse && !fail_flag, "R1 in reset",
        {ok_pulse, fail_pulse, fail_flag}, 0);
    xtal_rst_n = 1'b1; ref_rst_n = 1'b1;
    repeat (3) @(negedge ref_clk);
    chk(!ok_pulse && !fail_pulse && !fail_flag, "R1 after release",
        {ok_pulse, fail_pulse, fail_flag}, 0);
    enable = 1'b1;

    // R2/R3: sweep of crystal periods
    run_healthy(2.0, 12);
    run_healthy(2.2, 12);
    run_healthy(2.6, 12);
    run_healthy(3.0, 12);
    run_healthy(3.4, 12);

    // R4/R5/R6/R8: stop the crystal at every phase of its round
    xhalf = 2.0;
    wait_ok(40, n);
    xhalf = 2.2;
    for (int k = 0; k <= 8; k++) begin
      xrun = 1'b1;
      wait_ok(60, n);
      chk(n > 0, "R6 alive after restart", n, 1);
      if (k > 0) chk(fail_flag == 1'b1, "R6 flag before clear", fail_flag, 1);
      @(negedge ref_clk);
      chk(fail_flag == 1'b0, "R6 flag cleared", fail_flag, 0);
      wait_ok(40, n);
      c = 0; last_ok = 0; first_flag = -1; pulses = 0; lows = 0;
      for (int i = 0; i < k; i++) begin
        @(negedge ref_clk); c++;
        if (ok_pulse) last_ok = c;
      end
      xrun = 1'b0;
      for (int i = 0; i < FTC + 25; i++) begin
        @(negedge ref_clk); c++;
        if (ok_pulse) last_ok = c;
        if (fail_flag && first_flag < 0) first_flag = c;
        if (first_flag >= 0 && !fail_flag) lows++;
        if (fail_pulse) begin
          pulses++;
          chk(c == first_flag, "R4 pulse cycle", c, first_flag);
        end
      end
      chk(first_flag == last_ok + FTC + 1, "R4 expiry cycle", first_flag, last_ok + FTC + 1);
      chk(first_flag - k <= FTC + 5 && first_flag > 0, "R8 bound from stop",
          first_flag - k, FTC + 5);
      chk(pulses == 1, "R5 single pulse", pulses, 1);
      chk(lows == 0 && fail_flag, "R5 flag sticky", lows, 0);
    end

    // R7: disable while the flag is set, crystal stopped then running
    enable = 1'b0;
    okc = 0; pulses = 0; lows = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge ref_clk);
      if (!fail_flag) lows++;
      if (fail_pulse) pulses++;
    end
    xhalf = 2.0; xrun = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge ref_clk);
      if (ok_pulse) okc++;
      if (!fail_flag) lows++;
      if (fail_pulse) pulses++;
    end
    chk(lows == 0, "R7 flag kept while disabled", lows, 0);
    chk(pulses == 0, "R7 no expiry while disabled", pulses, 0);
    chk(okc == 0, "R7 no alive while disabled", okc, 0);
    enable = 1'b1;
    wait_ok(30, n);
    chk(n > 0, "R7 alive resumes", n, 1);
    @(negedge ref_clk);
    chk(fail_flag == 1'b0, "R6 clear after enable", fail_flag, 0);
    wait_ok(30, n);
    // R7: disabled with flag clear, crystal running, far longer than timeout
    enable = 1'b0;
    okc = 0; pulses = 0; lows = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge ref_clk);
      if (ok_pulse) okc++;
      if (fail_pulse || fail_flag) pulses++;
    end
    chk(okc == 0, "R7 alive gated", okc, 0);
    chk(pulses == 0, "R7 timeout frozen", pulses, 0);

    summary();
    $finish;
  end
endmodule